// File: doc/BRIEF.md
# Ring Station Parallel Bypass with Slot Drop and Insert

This block sits on the byte-wide parallel port of one station in a ring of time-division multiplexed stations. Every received byte is written into a circular delay buffer and leaves on the transmit side a programmable number of byte times later. On the way out, a per-slot control word decides what happens to the byte. It can be forwarded unchanged. It can be forwarded and also copied to the local drop interface. It can be replaced by a byte from the local insert interface. It can be withheld, with the output driver released. A per-slot message byte can replace any transmitted byte.

The frame-start mark travels through the delay buffer with its byte, so the transmit slot counter restarts exactly as many byte times after the receive frame start as the programmed latency. A CPU writes control words into a shadow table. The whole shadow table is copied into the active table at each transmit frame start, so one frame never runs with mixed settings. One byte moves per `byte_en` cycle, which lets the port run below the core clock rate.

Top module: `ring_bdi`

## Requirements
- R1: After reset, `tx_oe`, `tx_data`, `tx_slot`, `tx_fs`, `drop_valid` and `lat_err` are all zero, and every control entry is mode 00 with the message bit clear.
- R2: A byte accepted on a `byte_en` cycle is transmitted after L further byte events, where L is the effective latency in byte times.
- R3: When `latency` is below 2, `lat_err` is 1 from the next clock edge and L is 2. A value above LAT_DEPTH-1 gives L = LAT_DEPTH-1. Otherwise L equals `latency` and `lat_err` is 0.
- R4: The byte that was received with `rx_fs` is sent with a one-cycle `tx_fs` pulse and `tx_slot` = 0. Each following byte event advances `tx_slot` by one, wrapping from NUM_SLOTS-1 to 0.
- R5: In mode 00 (pass), the delayed received byte is sent with `tx_oe` = 1 and no drop.
- R6: In mode 01 (drop and pass), the delayed byte is sent, and `drop_valid` pulses with `drop_data` equal to that same byte.
- R7: In mode 10 (insert), `ins_rd` is high during the byte cycle and the `ins_data` sampled at that edge is sent. No drop occurs.
- R8: In mode 11 (idle), `tx_oe` is 0 and `tx_data` is 0.
- R9: With the message bit set, in modes 00, 01 and 10, `tx_data` is the entry's message byte. A drop still copies the received byte.
- R10: A control word is `{msg[7:0], msg_en, mode[1:0]}` (bits 10:3, 2, 1:0). A write reaches the active table only at the next transmit frame start. Writes to addresses at or above NUM_SLOTS are ignored.
- R11: In a cycle with `byte_en` low, `tx_data`, `tx_oe` and `tx_slot` hold, `tx_fs`, `drop_valid` and `ins_rd` are 0, and nothing enters the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_en | input | 1 | One byte moves on each side in this cycle |
| rx_data | input | 8 | Received ring byte |
| rx_fs | input | 1 | Received byte is slot 0 of a frame |
| latency | input | LAT_W | Requested delay in byte times |
| lat_err | output | 1 | Requested latency below the minimum of 2 |
| cpu_we | input | 1 | Control table write strobe |
| cpu_addr | input | SLOT_W | Slot number to write |
| cpu_wdata | input | 11 | Control word {msg, msg_en, mode} |
| tx_data | output | 8 | Transmitted ring byte |
| tx_oe | output | 1 | Output driver enable |
| tx_fs | output | 1 | Transmitted byte is slot 0 |
| tx_slot | output | SLOT_W | Slot number of the transmitted byte |
| drop_valid | output | 1 | Drop byte strobe |
| drop_data | output | 8 | Byte copied to the local station |
| ins_rd | output | 1 | Insert byte is taken at this edge |
| ins_data | input | 8 | Locally generated byte |

## Verification
The assertions assume that `byte_en` is the only pacing of the data path, that `ins_data` is valid in any cycle where `ins_rd` is high, and that the frame marks arriving on `rx_fs` may come at any spacing, including frames cut short. The stimulus gives `byte_en` a random duty cycle and holds `ins_data` random in every cycle. It places frame marks every NUM_SLOTS bytes, with rare early marks. Latency changes only between phases of the test. Values below the minimum and above the buffer depth are included, and the checker follows the clamped value rather than assuming the requested one. Bytes whose source lies before the first L events after reset are never compared, because the buffer RAM is not reset.

// File: rtl/ring_bdi_pkg.sv
package ring_bdi_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      MODE_PASS = 2'b00,
      MODE_DROP = 2'b01,
      MODE_INS  = 2'b10,
      MODE_IDLE = 2'b11
   } slot_mode_e;

   typedef struct packed {
      logic [BYTE_W-1:0] msg;
      logic              msg_en;
      slot_mode_e        mode;
   } slot_ctrl_t;

endpackage

// File: rtl/ring_bdi_slot_cnt.sv
module ring_bdi_slot_cnt #(
   parameter int NUM_SLOTS = 810,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              restart,
   output logic [SLOT_W-1:0] slot_nxt,
   output logic [SLOT_W-1:0] slot_q
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

   initial begin
      assert (NUM_SLOTS >= 2) else $error("slot count must be at least 2");
   end

   always_comb begin
      if (restart)              slot_nxt = '0;
      else if (slot_q == LAST)  slot_nxt = '0;
      else                      slot_nxt = slot_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    slot_q <= '0;
      else if (step) slot_q <= slot_nxt;
   end

   // R4
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(slot_q) < NUM_SLOTS);

endmodule

// File: rtl/ring_bdi_lat_buf.sv
module ring_bdi_lat_buf import ring_bdi_pkg::*; #(
   parameter int LAT_DEPTH = 1024,
   parameter int MIN_LAT   = 2,
   localparam int PW = $clog2(LAT_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_fs,
   input  logic [PW-1:0]     latency,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_fs,
   output logic              lat_low
);

   localparam logic [PW:0] MIN_L = (PW+1)'(MIN_LAT);
   localparam logic [PW:0] MAX_L = (PW+1)'(LAT_DEPTH - 1);
   localparam logic [PW:0] DEP_X = (PW+1)'(LAT_DEPTH);

   initial begin
      assert (LAT_DEPTH > MIN_LAT) else $error("buffer shallower than minimum latency");
      assert (MIN_LAT >= 1) else $error("minimum latency must be positive");
   end

   logic [BYTE_W-1:0] mem_q [LAT_DEPTH];
   logic [LAT_DEPTH-1:0] fs_q;
   logic [PW-1:0] wptr_q;
   logic [PW-1:0] wptr_nxt;
   logic [PW-1:0] rd_idx;
   logic [PW:0]   lat_x;
   logic [PW:0]   lat_eff;

   assign lat_x   = {1'b0, latency};
   assign lat_low = (lat_x < MIN_L);

   always_comb begin
      if (lat_x < MIN_L)      lat_eff = MIN_L;
      else if (lat_x > MAX_L) lat_eff = MAX_L;
      else                    lat_eff = lat_x;
   end

   generate
      if ((1 << PW) == LAT_DEPTH) begin : g_pow2
         assign wptr_nxt = wptr_q + 1'b1;
         assign rd_idx   = wptr_q - lat_eff[PW-1:0];
      end else begin : g_wrap
         logic [PW:0] wx;
         assign wx       = {1'b0, wptr_q};
         assign wptr_nxt = (wptr_q == PW'(LAT_DEPTH - 1)) ? '0 : wptr_q + 1'b1;
         assign rd_idx   = (wx >= lat_eff) ? PW'(wx - lat_eff)
                                           : PW'(wx + DEP_X - lat_eff);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wptr_q] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         fs_q   <= '0;
      end else if (wr_en) begin
         wptr_q         <= wptr_nxt;
         fs_q[wptr_q]   <= wr_fs;
      end
   end

   assign rd_data = mem_q[rd_idx];
   assign rd_fs   = fs_q[rd_idx];

   // R11
   wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wptr_q));

   // R3
   dist_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_idx != wptr_q);

endmodule

// File: rtl/ring_bdi_ctrl_mem.sv
module ring_bdi_ctrl_mem import ring_bdi_pkg::*; #(
   parameter int NUM_SLOTS = 810,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [SLOT_W-1:0] cpu_addr,
   input  slot_ctrl_t        cpu_wdata,
   input  logic              commit,
   input  logic [SLOT_W-1:0] rd_slot,
   output slot_ctrl_t        rd_ctrl
);

   slot_ctrl_t shadow_q [NUM_SLOTS];
   slot_ctrl_t active_q [NUM_SLOTS];
   logic       addr_ok;

   assign addr_ok = (int'(cpu_addr) < NUM_SLOTS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SLOTS; s++) begin
            shadow_q[s] <= '0;
            active_q[s] <= '0;
         end
      end else begin
         if (commit) begin
            for (int s = 0; s < NUM_SLOTS; s++) active_q[s] <= shadow_q[s];
         end
         if (cpu_we && addr_ok) shadow_q[cpu_addr] <= cpu_wdata;
      end
   end

   assign rd_ctrl = commit ? shadow_q[rd_slot] : active_q[rd_slot];

   // R10
   frame_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active_q[0]));

endmodule

// File: rtl/ring_bdi.sv
module ring_bdi import ring_bdi_pkg::*; #(
   parameter int NUM_SLOTS = 810,
   parameter int LAT_DEPTH = 1024,
   parameter int MIN_LAT   = 2,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int LAT_W  = $clog2(LAT_DEPTH),
   localparam int CTRL_W = $bits(slot_ctrl_t)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_en,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_fs,
   input  logic [LAT_W-1:0]  latency,
   output logic              lat_err,
   input  logic              cpu_we,
   input  logic [SLOT_W-1:0] cpu_addr,
   input  logic [CTRL_W-1:0] cpu_wdata,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_oe,
   output logic              tx_fs,
   output logic [SLOT_W-1:0] tx_slot,
   output logic              drop_valid,
   output logic [BYTE_W-1:0] drop_data,
   output logic              ins_rd,
   input  logic [BYTE_W-1:0] ins_data
);

   initial begin
      assert (LAT_DEPTH >= NUM_SLOTS || LAT_DEPTH > MIN_LAT)
         else $error("latency buffer too small");
   end

   logic [BYTE_W-1:0] dly_data;
   logic              dly_fs;
   logic              lat_low;
   logic [SLOT_W-1:0] slot_nxt;
   logic [SLOT_W-1:0] slot_q;
   logic              commit;
   slot_ctrl_t        cur;
   logic [BYTE_W-1:0] out_byte;
   logic              out_en;

   ring_bdi_lat_buf #(.LAT_DEPTH(LAT_DEPTH), .MIN_LAT(MIN_LAT)) i_lat_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(byte_en), .wr_data(rx_data), .wr_fs(rx_fs),
      .latency(latency), .rd_data(dly_data), .rd_fs(dly_fs), .lat_low(lat_low)
   );

   ring_bdi_slot_cnt #(.NUM_SLOTS(NUM_SLOTS)) i_tx_cnt (
      .clk(clk), .rst_n(rst_n), .step(byte_en), .restart(dly_fs),
      .slot_nxt(slot_nxt), .slot_q(slot_q)
   );

   assign commit = byte_en & dly_fs;

   ring_bdi_ctrl_mem #(.NUM_SLOTS(NUM_SLOTS)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(slot_ctrl_t'(cpu_wdata)), .commit(commit),
      .rd_slot(slot_nxt), .rd_ctrl(cur)
   );

   always_comb begin
      out_en = (cur.mode != MODE_IDLE);
      unique case (cur.mode)
         MODE_INS:  out_byte = ins_data;
         MODE_IDLE: out_byte = '0;
         default:   out_byte = dly_data;
      endcase
      if (out_en && cur.msg_en) out_byte = cur.msg;
   end

   assign ins_rd  = byte_en && (cur.mode == MODE_INS);
   assign tx_slot = slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_data    <= '0;
         tx_oe      <= 1'b0;
         tx_fs      <= 1'b0;
         drop_valid <= 1'b0;
         drop_data  <= '0;
         lat_err    <= 1'b0;
      end else begin
         lat_err    <= lat_low;
         tx_fs      <= commit;
         drop_valid <= byte_en && (cur.mode == MODE_DROP);
         if (byte_en) begin
            tx_data <= out_byte;
            tx_oe   <= out_en;
            if (cur.mode == MODE_DROP) drop_data <= dly_data;
         end
      end
   end

   // R4
   fs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fs |-> (tx_slot == '0));

   // R6
   drop_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_valid |-> tx_oe);

   // R7
   ins_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_rd |=> (!drop_valid && tx_oe));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_en |=> ($stable(tx_data) && $stable(tx_slot) && !tx_fs && !drop_valid));

endmodule

// File: tb/test_ring_bdi.sv
module test_ring_bdi;

   localparam int N  = 20;
   localparam int D  = 24;
   localparam int SW = $clog2(N);
   localparam int LW = $clog2(D);
   localparam int CW = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic byte_en = 1'b0;
   logic [7:0] rx_data = '0;
   logic rx_fs = 1'b0;
   logic [LW-1:0] latency = LW'(5);
   logic lat_err;
   logic cpu_we = 1'b0;
   logic [SW-1:0] cpu_addr = '0;
   logic [CW-1:0] cpu_wdata = '0;
   logic [7:0] tx_data;
   logic tx_oe, tx_fs, drop_valid, ins_rd;
   logic [SW-1:0] tx_slot;
   logic [7:0] drop_data;
   logic [7:0] ins_data = '0;

   always #2 clk = ~clk;

   ring_bdi #(.NUM_SLOTS(N), .LAT_DEPTH(D)) i_ring_bdi (
      .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .rx_data(rx_data), .rx_fs(rx_fs),
      .latency(latency), .lat_err(lat_err), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .tx_data(tx_data), .tx_oe(tx_oe), .tx_fs(tx_fs),
      .tx_slot(tx_slot), .drop_valid(drop_valid), .drop_data(drop_data),
      .ins_rd(ins_rd), .ins_data(ins_data)
   );

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [CW-1:0] shadow_m [N];
   logic [CW-1:0] active_m [N];
   logic [7:0] hd [64];
   bit hf [64];
   int n_ev = 0;
   int cnt_m = 0;
   int rx_pos = 0;
   int lat_cfg = 5;

   logic [7:0] e_data = '0, e_dd = '0;
   bit e_oe = 0, e_fs = 0, e_dv = 0, e_le = 0, e_known = 1, e_ddk = 0;
   int e_slot = 0;
   string e_tag = "R1";

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int eff_lat(input int l);
      if (l < 2) return 2;
      if (l > D - 1) return D - 1;
      return l;
   endfunction

   task automatic check_outputs();
      chk(tx_fs === e_fs, "R4", int'(tx_fs), int'(e_fs));
      chk(int'(tx_slot) == e_slot, "R4", int'(tx_slot), e_slot);
      chk(tx_oe === e_oe, e_tag, int'(tx_oe), int'(e_oe));
      if (e_known) chk(tx_data === e_data, e_tag, int'(tx_data), int'(e_data));
      chk(drop_valid === e_dv, "R6", int'(drop_valid), int'(e_dv));
      if (e_dv && e_ddk) chk(drop_data === e_dd, "R6", int'(drop_data), int'(e_dd));
      chk(lat_err === e_le, "R3", int'(lat_err), int'(e_le));
   endtask

   task automatic cycle(input int p_en, input bit do_cpu);
      int l;
      @(negedge clk);
      check_outputs();
      latency  = LW'(lat_cfg);
      byte_en  = (($urandom % 100) < p_en);
      rx_data  = 8'($urandom);
      rx_fs    = byte_en && ((rx_pos == 0) || (($urandom % 100) == 0));
      ins_data = 8'($urandom);
      cpu_we   = do_cpu && (($urandom % 100) < 6);
      cpu_addr = SW'($urandom);
      cpu_wdata = CW'($urandom);
      #1;
      l = eff_lat(lat_cfg);
      e_le = (lat_cfg < 2);
      if (byte_en) begin
         bit fs_rd, known, pend, men;
         logic [7:0] d_rd, msg;
         logic [CW-1:0] c;
         int slot, mode;
         known = (n_ev >= l);
         fs_rd = known ? hf[(n_ev - l) % 64] : 1'b0;
         d_rd  = hd[(n_ev - l + 64) % 64];
         slot  = fs_rd ? 0 : ((cnt_m == N - 1) ? 0 : cnt_m + 1);
         c     = fs_rd ? shadow_m[slot] : active_m[slot];
         pend  = !fs_rd && (shadow_m[slot] != active_m[slot]);
         mode  = int'(c[1:0]);
         men   = c[2];
         msg   = c[10:3];
         chk(ins_rd === (mode == 2), "R7", int'(ins_rd), int'(mode == 2));
         e_oe  = (mode != 3);
         if (mode == 3) e_data = '0;
         else if (men) e_data = msg;
         else if (mode == 2) e_data = ins_data;
         else e_data = d_rd;
         e_known = (mode == 3 || men || mode == 2) ? 1'b1 : known;
         case (mode)
            0: e_tag = "R2 R5";
            1: e_tag = "R2 R6";
            2: e_tag = "R7";
            default: e_tag = "R8";
         endcase
         if (men && mode != 3) e_tag = "R9";
         if (pend) e_tag = {e_tag, " R10"};
         e_dv  = (mode == 1);
         e_dd  = d_rd;
         e_ddk = known;
         e_fs  = fs_rd;
         e_slot = slot;
         cnt_m = slot;
         if (fs_rd) for (int s = 0; s < N; s++) active_m[s] = shadow_m[s];
         hd[n_ev % 64] = rx_data;
         hf[n_ev % 64] = rx_fs;
         n_ev++;
         rx_pos = rx_fs ? 1 : rx_pos + 1;
         if (rx_pos >= N) rx_pos = 0;
      end else begin
         chk(ins_rd === 1'b0, "R11", int'(ins_rd), 0);
         e_fs = 0;
         e_dv = 0;
         e_tag = "R11";
      end
      if (cpu_we && int'(cpu_addr) < N) shadow_m[int'(cpu_addr)] = cpu_wdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5a17));
      for (int s = 0; s < N; s++) begin
         shadow_m[s] = '0;
         active_m[s] = '0;
      end
      for (int i = 0; i < 64; i++) begin
         hd[i] = '0;
         hf[i] = 1'b0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(tx_oe === 1'b0, "R1", int'(tx_oe), 0);
      chk(tx_data === 8'h00, "R1", int'(tx_data), 0);
      chk(tx_fs === 1'b0, "R1", int'(tx_fs), 0);
      chk(tx_slot === '0, "R1", int'(tx_slot), 0);
      chk(drop_valid === 1'b0, "R1", int'(drop_valid), 0);
      chk(lat_err === 1'b0, "R1", int'(lat_err), 0);
      // R2 R5: all slots pass, full rate then paced
      lat_cfg = 5;
      repeat (100) cycle(100, 0);
      repeat (200) cycle(70, 0);
      // R6 R7 R8 R9 R10: random control writes
      lat_cfg = 7;
      repeat (3000) cycle(75, 1);
      // R3: below minimum, zero, above depth, exact minimum
      lat_cfg = 1;
      repeat (500) cycle(80, 1);
      lat_cfg = 0;
      repeat (200) cycle(80, 1);
      lat_cfg = 31;
      repeat (500) cycle(80, 1);
      lat_cfg = 2;
      repeat (500) cycle(100, 1);
      // R11: long idle stretch
      lat_cfg = 9;
      repeat (300) cycle(20, 1);
      @(negedge clk);
      check_outputs();
      finish_run();
   end

endmodule